// File: doc/BRIEF.md
# Clock Gate Mask Controller

This block drives the enable inputs of the clock gates for a set of peripheral clock domains. The domains are arranged as a number of groups, and each group has its own mask register. Software writes a group's mask register to choose which of its domains receive a clock. A written value first passes through a synchronizer and one gate-update stage before it reaches the enable outputs. A ready status flag tells software when every enable output matches the latest written masks. This matters most after domains are re-enabled, because a module must not be accessed before its clock is running again.

An interrupt can be raised from the ready flag, and it has separate set, clear and read-back registers for its enable. A per-domain sleep-stop input turns a domain off at once, whatever its mask bit holds. Writes are single-cycle strobes. Reads come back combinationally from the read address.

Top module: `clk_gate_mask`

## Requirements
- R1: A mask write can be read back at once. The enable outputs for that group keep their old value for the first two cycles after the write edge and show the new value from the third rising edge after it.
- R2: Any mask-register write clears the ready flag from the cycle after the write edge, even when the written value equals the stored mask.
- R3: The ready flag sets on the third rising edge after the last mask write. From then on the enable outputs (before the sleep override) equal the masks of every group, whether domains were enabled or disabled.
- R4: A mask write made while an earlier one is still in flight restarts the delay. Ready then sets three edges after the later write, and the intermediate value may appear at the enables for a cycle while ready stays low.
- R5: A high sleep_stop_i bit forces its gate enable low in the same cycle, even when the mask bit is 1. It does not change the stored mask or the ready flag, and releasing the bit restores the enable.
- R6: irq_o is high exactly when the ready flag and the interrupt-enable bit are both 1. Writing 1 to bit 0 of the enable-set register sets the enable bit, and writing 1 to bit 0 of the enable-clear register clears it. Writing 0 to bit 0 of either register has no effect.
- R7: Writing 1 to bit 0 of the clear register drops the ready flag and leaves the enables untouched. If the delay completes on the same edge, the flag still sets.
- R8: After reset every mask bit and every enable is 1, the ready flag is 1 and the interrupt enable is 0.
- R9: Register addresses with two groups are: group masks at 0 and 1, enable-set 2, enable-clear 3, enable read-back 4 (bit 0), clear 5, status 6 (bit 0 = ready). Any other read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | NUM_DOM | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | NUM_DOM | Read data, combinational |
| sleep_stop_i | input | NUM_GRP*NUM_DOM | Per-domain forced stop from the sleep controller |
| gate_en_o | output | NUM_GRP*NUM_DOM | Clock gate enables, group g at bits [g*NUM_DOM +: NUM_DOM] |
| irq_o | output | 1 | Mask-ready interrupt |

## Verification
Suppose the delay counter or the pipeline stages are off by one. The bench would then see ready rise a cycle too early or too late, or see an enable change on the wrong edge, because it samples every cycle of the three-cycle window. A stale gate stage left with ready set shows up as an enable that differs from the read-back mask while the status reads 1. A lost interrupt-enable or a wrong clear priority shows on irq_o and on the status read within one cycle of the write that caused it.

// File: rtl/cgm_pkg.sv
package cgm_pkg;
  // control registers sit directly above the group mask registers
  typedef enum logic [2:0] {
    K_IER  = 3'd0,
    K_IDR  = 3'd1,
    K_IMR  = 3'd2,
    K_ICR  = 3'd3,
    K_STAT = 3'd4
  } ctrl_kind_e;

  localparam int unsigned NUM_CTRL  = 5;
  localparam int unsigned READY_BIT = 0;
endpackage

// File: rtl/cgm_mask_regs.sv
module cgm_mask_regs #(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned NUM_DOM = 8,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [NUM_DOM-1:0]         wr_data_i,
  output logic [NUM_GRP*NUM_DOM-1:0] mask_o,
  output logic                       mask_wr_o
);
  logic [NUM_GRP-1:0] hit;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic [NUM_DOM-1:0] mask_q;
    assign hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     mask_q <= '1;
      else if (hit[g]) mask_q <= wr_data_i;
    end

    assign mask_o[g*NUM_DOM +: NUM_DOM] = mask_q;
  end

  assign mask_wr_o = |hit;
endmodule

// File: rtl/cgm_sync.sv
module cgm_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] gate_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;
  logic [W-1:0]             gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      gate_q <= '1;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
      gate_q <= pipe_q[STAGES-1];
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/cgm_ready.sv
module cgm_ready #(
  parameter int unsigned DELAY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mask_wr_i,
  input  logic ier_set_i,
  input  logic idr_set_i,
  input  logic icr_clr_i,
  output logic ready_o,
  output logic imr_o,
  output logic irq_o
);
  localparam int unsigned CNT_W = $clog2(DELAY + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ready_q;
  logic             imr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (mask_wr_i)     cnt_q <= CNT_W'(DELAY);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // write clears first, completion beats a software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    ready_q <= 1'b1;
    else if (mask_wr_i)             ready_q <= 1'b0;
    else if (cnt_q == CNT_W'(1))    ready_q <= 1'b1;
    else if (icr_clr_i)             ready_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        imr_q <= 1'b0;
    else if (ier_set_i) imr_q <= 1'b1;
    else if (idr_set_i) imr_q <= 1'b0;
  end

  assign ready_o = ready_q;
  assign imr_o   = imr_q;
  assign irq_o   = ready_q & imr_q;

  a_r2_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> !ready_q);
  a_r4_pending_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> !ready_q);
  a_r7_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_q) |-> $past(mask_wr_i || icr_clr_i));
endmodule

// File: rtl/clk_gate_mask.sv
module clk_gate_mask
  import cgm_pkg::*;
#(
  parameter int unsigned NUM_GRP     = 2,
  parameter int unsigned NUM_DOM     = 8,
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [NUM_DOM-1:0]         wr_data_i,
  input  logic [ADDR_W-1:0]          rd_addr_i,
  output logic [NUM_DOM-1:0]         rd_data_o,
  input  logic [NUM_GRP*NUM_DOM-1:0] sleep_stop_i,
  output logic [NUM_GRP*NUM_DOM-1:0] gate_en_o,
  output logic                       irq_o
);
  localparam int unsigned W     = NUM_GRP * NUM_DOM;
  localparam int unsigned DELAY = SYNC_STAGES + 1;
  localparam logic [ADDR_W-1:0] A_IER  = ADDR_W'(NUM_GRP + int'(K_IER));
  localparam logic [ADDR_W-1:0] A_IDR  = ADDR_W'(NUM_GRP + int'(K_IDR));
  localparam logic [ADDR_W-1:0] A_IMR  = ADDR_W'(NUM_GRP + int'(K_IMR));
  localparam logic [ADDR_W-1:0] A_ICR  = ADDR_W'(NUM_GRP + int'(K_ICR));
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_GRP + int'(K_STAT));

  logic [W-1:0] mask_q;
  logic [W-1:0] gate_q;
  logic         mask_wr;
  logic         ready;
  logic         imr;
  logic         ier_set, idr_set, icr_clr;

  cgm_mask_regs #(.NUM_GRP(NUM_GRP), .NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .mask_o(mask_q), .mask_wr_o(mask_wr)
  );

  cgm_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(mask_q), .gate_o(gate_q)
  );

  assign ier_set = wr_en_i && (wr_addr_i == A_IER) && wr_data_i[READY_BIT];
  assign idr_set = wr_en_i && (wr_addr_i == A_IDR) && wr_data_i[READY_BIT];
  assign icr_clr = wr_en_i && (wr_addr_i == A_ICR) && wr_data_i[READY_BIT];

  cgm_ready #(.DELAY(DELAY)) i_ready (
    .clk_i, .rst_ni, .mask_wr_i(mask_wr),
    .ier_set_i(ier_set), .idr_set_i(idr_set), .icr_clr_i(icr_clr),
    .ready_o(ready), .imr_o(imr), .irq_o
  );

  // sleep stop bypasses the synchronizer and wins over the mask
  assign gate_en_o = gate_q & ~sleep_stop_i;

  always_comb begin
    rd_data_o = '0;
    for (int g = 0; g < int'(NUM_GRP); g++)
      if (rd_addr_i == ADDR_W'(g)) rd_data_o = mask_q[g*NUM_DOM +: NUM_DOM];
    if (rd_addr_i == A_IMR)  rd_data_o[READY_BIT] = imr;
    if (rd_addr_i == A_STAT) rd_data_o[READY_BIT] = ready;
  end

  a_r3_ready_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready |-> (gate_q == mask_q));
  a_r1_settled_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && !mask_wr) |=> $stable(gate_q));
  initial a_r9_map_fits: assert (NUM_GRP + NUM_CTRL <= (1 << ADDR_W));
endmodule

// File: tb/test_clk_gate_mask.sv
`timescale 1ns/1ps
module test_clk_gate_mask;
  localparam int NG = 2, ND = 8, AW = 3;
  localparam logic [AW-1:0] A_M0 = 0, A_M1 = 1, A_IER = 2, A_IDR = 3,
                            A_IMR = 4, A_ICR = 5, A_STAT = 6;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [ND-1:0] wr_data = '0, rd_data;
  logic [NG*ND-1:0] sleep_stop = '0, gate_en;
  logic irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  clk_gate_mask i_clk_gate_mask (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .sleep_stop_i(sleep_stop), .gate_en_o(gate_en), .irq_o(irq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // called at a negedge, returns at the negedge after the write edge
  task automatic wr(logic [AW-1:0] a, logic [ND-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, int exp);
    rd_addr = a;
    #0.5;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic t_reset();
    chk("R8 gate_en", int'(gate_en), 16'hffff);
    chk("R8 irq", int'(irq), 0);
    rd_chk("R8 mask0", A_M0, 8'hff);
    rd_chk("R8 mask1", A_M1, 8'hff);
    rd_chk("R8 ready", A_STAT, 1);
    rd_chk("R8 imr", A_IMR, 0);
    rd_chk("R9 unused addr", 3'd7, 0);
  endtask

  task automatic t_disable();
    step();
    wr(A_M0, 8'h0f);
    rd_chk("R1 readback", A_M0, 8'h0f);
    rd_chk("R2 ready cleared", A_STAT, 0);
    chk("R1 gate t+0", int'(gate_en), 16'hffff);
    step();
    chk("R1 gate t+1", int'(gate_en), 16'hffff);
    step();
    chk("R1 gate t+2", int'(gate_en), 16'hffff);
    rd_chk("R3 not ready t+2", A_STAT, 0);
    step();
    chk("R1 gate t+3", int'(gate_en), 16'hff0f);
    rd_chk("R3 ready t+3", A_STAT, 1);
  endtask

  task automatic t_same_value();
    step();
    wr(A_M0, 8'h0f);
    rd_chk("R2 same value clears", A_STAT, 0);
    step(); step(); step();
    rd_chk("R3 ready after same", A_STAT, 1);
    chk("R3 gate unchanged", int'(gate_en), 16'hff0f);
  endtask

  task automatic t_enable();
    step();
    wr(A_M0, 8'hf3);
    step(); step();
    chk("R3 enable t+2", int'(gate_en), 16'hff0f);
    step();
    chk("R3 enable t+3", int'(gate_en), 16'hfff3);
    rd_chk("R3 ready enable", A_STAT, 1);
  endtask

  task automatic t_restart();
    step();
    wr(A_M1, 8'h3c);
    wr(A_M1, 8'h55);
    rd_chk("R4 latest readback", A_M1, 8'h55);
    step();
    chk("R4 gate old", int'(gate_en), 16'hfff3);
    step();
    chk("R4 intermediate", int'(gate_en), 16'h3cf3);
    rd_chk("R4 not ready yet", A_STAT, 0);
    step();
    chk("R4 final gate", int'(gate_en), 16'h55f3);
    rd_chk("R4 ready late", A_STAT, 1);
  endtask

  task automatic t_irq();
    step();
    chk("R6 irq off no enable", int'(irq), 0);
    wr(A_IER, 8'hfe);
    rd_chk("R6 ier bit0 zero", A_IMR, 0);
    chk("R6 irq still off", int'(irq), 0);
    step();
    wr(A_IER, 8'h01);
    rd_chk("R6 imr set", A_IMR, 1);
    chk("R6 irq on", int'(irq), 1);
    step();
    wr(A_IDR, 8'h00);
    chk("R6 idr bit0 zero", int'(irq), 1);
    step();
    wr(A_ICR, 8'h01);
    rd_chk("R7 icr clears ready", A_STAT, 0);
    chk("R7 irq after icr", int'(irq), 0);
    chk("R7 gates kept", int'(gate_en), 16'h55f3);
    step();
    wr(A_M1, 8'h55);
    step(); step();
    chk("R6 irq waits", int'(irq), 0);
    step();
    chk("R6 irq on ready", int'(irq), 1);
    step();
    wr(A_IDR, 8'h01);
    chk("R6 irq disabled", int'(irq), 0);
    rd_chk("R6 imr cleared", A_IMR, 0);
  endtask

  task automatic t_icr_race();
    step();
    wr(A_M0, 8'hff);
    step();
    step();
    wr(A_ICR, 8'h01);
    rd_chk("R7 completion wins", A_STAT, 1);
    chk("R7 race gate", int'(gate_en), 16'h55ff);
  endtask

  task automatic t_sleep();
    step();
    sleep_stop = 16'h0181;
    #0.5;
    chk("R5 forced off", int'(gate_en), 16'h547e);
    rd_chk("R5 mask kept", A_M0, 8'hff);
    rd_chk("R5 ready kept", A_STAT, 1);
    step();
    chk("R5 held off", int'(gate_en), 16'h547e);
    sleep_stop = '0;
    #0.5;
    chk("R5 released", int'(gate_en), 16'h55ff);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_disable();
    t_same_value();
    t_enable();
    t_restart();
    t_irq();
    t_icr_race();
    t_sleep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule